// File: doc/BRIEF.md
# UART Interrupt Source, Mask and Pending Unit

This block keeps the interrupt bookkeeping of a single UART channel. Four event inputs (receive, error, transmit and modem status) latch into a sticky source register. A mask register removes the sources that software does not want to see. The visible pending vector is the source vector with the masked bits removed. One level-sensitive interrupt line is raised while any pending bit is set.

Software clears interrupts by writing ones to either the pending view or the source register. The transmit source is also refilled automatically. While the FIFO is enabled and the transmit FIFO holds no more entries than a trigger level, the source bit is set again. The trigger level is taken from a three-bit field and scaled by the FIFO depth. Every byte written for transmission also sets the transmit source. The block does not produce the events or move data. It only combines the events into the interrupt.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source register and the mask register are all zero, and the interrupt output is low.
- R2: Source bit positions are receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3. A one-cycle pulse on an event input sets its bit from the next clock edge, and the bit stays set until it is cleared.
- R3: The pending output equals the source register AND NOT the mask register. The interrupt output is high exactly when any pending bit is one.
- R4: A pending write with data bit i = 1 clears source bit i, and so also pending bit i, from the next edge. Data bits that are 0 leave their bits unchanged.
- R5: A source write with data bit i = 1 clears source bit i from the next edge. Data bits that are 0 leave their bits unchanged.
- R6: A mask write loads the mask from the next edge. Pending and the interrupt output follow in that same cycle, with no further delay.
- R7: The transmit trigger level is the 3-bit trigger field times DEPTH/8 (×2 for 16 entries, ×8 for 64 entries, ×32 for 256 entries). While the FIFO is enabled and the transmit count is at or below this level, the transmit source bit is set on every edge.
- R8: While the FIFO is disabled, the transmit count and the trigger field have no effect on the source register.
- R9: A pulse on the transmit-byte-written input sets the transmit source bit.
- R10: If an event and a clear write hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_txw | input | 1 | Pulse for each byte written to the transmit data register |
| ev_modem | input | 1 | Modem status event pulse |
| fifo_en | input | 1 | FIFO enable |
| tx_trig | input | 3 | Transmit trigger field |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| wr_src | input | 1 | Write strobe, source register (write one to clear) |
| wr_pend | input | 1 | Write strobe, pending view (write one to clear) |
| wr_mask | input | 1 | Write strobe, mask register |
| wr_data | input | 4 | Write data |
| src_q | output | 4 | Source register |
| pend_q | output | 4 | Pending vector |
| mask_q | output | 4 | Mask register |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a clear that loses against a set in the same cycle. One form is an explicit event pulse. The other is the transmit refill, which keeps asserting itself as long as the FIFO count stays at or below the level. The bench reaches it by driving a pulse and a write-one-to-clear at the same falling edge. It also parks the transmit count just at and just above the scaled level, so that a clear is seen to stick in one case and to be undone in the other. The mask path is tested with sources already set, so that a mask write alone moves the interrupt line.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 4;
  localparam int SRC_RX  = 0;
  localparam int SRC_ERR = 1;
  localparam int SRC_TX  = 2;
  localparam int SRC_MDM = 3;
  localparam int TRIG_W = 3;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                             fifo_en,
  input  logic [uart_irq_pkg::TRIG_W-1:0]  field,
  input  logic [CNT_W-1:0]                 count,
  output logic                             hit
);
  localparam int SHIFT = (DEPTH >= 8) ? $clog2(DEPTH) - 3 : 0;
  logic [CNT_W+2:0] level;

  generate
    if (DEPTH >= 8) begin : g_scaled
      always_comb level = (CNT_W+3)'(field) << SHIFT;
    end else begin : g_unscaled
      always_comb level = (CNT_W+3)'(field);
    end
  endgenerate

  always_comb hit = fifo_en && ((CNT_W+3)'(count) <= level);
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  logic [N-1:0] q_nx;

  always_comb begin
    q_nx = (q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chk
      // R10 / R2: a set bit is present after the edge, whatever the clear did
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[gi] |=> q[gi]);
      // R4 / R5: a clear without a set empties the bit
      a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[gi] && !set_v[gi]) |=> !q[gi]);
      // R2: sticky without a clear
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q[gi] && !clr_v[gi]) |=> q[gi]);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mask,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] src,
  output logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] mask_nx;

  always_comb begin
    mask_nx = mask;
    if (wr_mask) mask_nx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_nx;
  end

  always_comb begin
    pend = src & ~mask;
    irq  = |pend;
  end

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == $past(wr_data)));
  a_r3_irq_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (src != '0));
  a_r3_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rx,
  input  logic             ev_err,
  input  logic             ev_txw,
  input  logic             ev_modem,
  input  logic             fifo_en,
  input  logic [2:0]       tx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             wr_src,
  input  logic             wr_pend,
  input  logic             wr_mask,
  input  logic [3:0]       wr_data,
  output logic [3:0]       src_q,
  output logic [3:0]       pend_q,
  output logic [3:0]       mask_q,
  output logic             irq
);
  import uart_irq_pkg::*;

  logic     tx_hit;
  src_vec_t set_v;
  src_vec_t clr_v;

  uart_irq_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .fifo_en (fifo_en),
    .field   (tx_trig),
    .count   (tx_count),
    .hit     (tx_hit)
  );

  always_comb begin
    set_v          = '0;
    set_v[SRC_RX]  = ev_rx;
    set_v[SRC_ERR] = ev_err;
    set_v[SRC_TX]  = ev_txw | tx_hit;
    set_v[SRC_MDM] = ev_modem;
    clr_v = '0;
    if (wr_src)  clr_v = clr_v | wr_data;
    if (wr_pend) clr_v = clr_v | wr_data;
  end

  uart_irq_src #(.N(NSRC)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (set_v),
    .clr_v (clr_v),
    .q     (src_q)
  );

  uart_irq_gate #(.N(NSRC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .src     (src_q),
    .mask    (mask_q),
    .pend    (pend_q),
    .irq     (irq)
  );

  // R7: a trigger hit re-arms the transmit source on the next edge
  a_r7_tx_refill: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |=> src_q[SRC_TX]);
  // R8: no trigger hit while the FIFO is off
  a_r8_fifo_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !tx_hit);
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 0;
  logic rst_n;
  logic ev_rx, ev_err, ev_txw, ev_modem, fifo_en;
  logic [2:0] tx_trig;
  logic [CNT_W-1:0] tx_count;
  logic wr_src, wr_pend, wr_mask;
  logic [3:0] wr_data;
  logic [3:0] src_q, pend_q, mask_q;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err), .ev_txw(ev_txw),
    .ev_modem(ev_modem), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .wr_src(wr_src), .wr_pend(wr_pend), .wr_mask(wr_mask), .wr_data(wr_data),
    .src_q(src_q), .pend_q(pend_q), .mask_q(mask_q), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    ev_rx = 0; ev_err = 0; ev_txw = 0; ev_modem = 0;
    wr_src = 0; wr_pend = 0; wr_mask = 0; wr_data = 0;
  endtask

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic clear_all();
    @(negedge clk); idle(); wr_src = 1; wr_data = 4'hF; step();
    @(negedge clk); idle(); wr_mask = 1; wr_data = 4'h0; step();
  endtask

  task automatic t_reset();
    chk("R1 src", src_q, 0);
    chk("R1 mask", mask_q, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_events();
    @(negedge clk); idle(); ev_rx = 1; step();
    chk("R2 rx bit0", src_q, 4'h1);
    chk("R3 irq rx", irq, 1);
    @(negedge clk); idle(); ev_err = 1; step();
    chk("R2 err bit1", src_q, 4'h3);
    @(negedge clk); idle(); ev_modem = 1; step();
    chk("R2 modem bit3", src_q, 4'hB);
    repeat (3) @(negedge clk);
    chk("R2 sticky", src_q, 4'hB);
  endtask

  task automatic t_pend_clear();
    @(negedge clk); idle(); wr_pend = 1; wr_data = 4'h2; step();
    chk("R4 pend clr err", src_q, 4'h9);
    chk("R4 pend view", pend_q, 4'h9);
  endtask

  task automatic t_src_clear();
    @(negedge clk); idle(); wr_src = 1; wr_data = 4'h8; step();
    chk("R5 src clr modem", src_q, 4'h1);
    @(negedge clk); idle(); wr_src = 1; wr_data = 4'h1; step();
    chk("R5 src empty", src_q, 4'h0);
    chk("R3 irq low", irq, 0);
  endtask

  task automatic t_mask();
    @(negedge clk); idle(); ev_rx = 1; ev_modem = 1; step();
    @(negedge clk); idle(); wr_mask = 1; wr_data = 4'h1; step();
    chk("R6 mask loaded", mask_q, 4'h1);
    chk("R3 pend masked", pend_q, 4'h8);
    chk("R3 irq still", irq, 1);
    @(negedge clk); idle(); wr_mask = 1; wr_data = 4'h9; step();
    chk("R6 irq drops", irq, 0);
    chk("R3 src kept", src_q, 4'h9);
    @(negedge clk); idle(); wr_mask = 1; wr_data = 4'h1; step();
    chk("R6 irq returns", irq, 1);
    clear_all();
  endtask

  task automatic t_trigger();
    // trigger field 3 on 64 entries -> level 24
    tx_trig = 3'd3; tx_count = CNT_W'(25); fifo_en = 1;
    step();
    @(negedge clk); idle(); wr_src = 1; wr_data = 4'h4; step();
    chk("R7 above level stays clear", src_q, 4'h0);
    tx_count = CNT_W'(24);
    step();
    chk("R7 at level sets tx", src_q, 4'h4);
    @(negedge clk); idle(); wr_pend = 1; wr_data = 4'h4; step();
    chk("R7 refill beats clear", src_q, 4'h4);
    tx_trig = 3'd0; tx_count = CNT_W'(1);
    @(negedge clk); idle(); wr_src = 1; wr_data = 4'h4; step();
    chk("R7 field0 count1 clear", src_q, 4'h0);
    tx_trig = 3'd7; tx_count = CNT_W'(56);
    step();
    chk("R7 field7 level56", src_q, 4'h4);
    fifo_en = 0;
    clear_all();
  endtask

  task automatic t_fifo_off();
    fifo_en = 0; tx_trig = 3'd7; tx_count = 0;
    repeat (3) step();
    chk("R8 no refill when off", src_q, 4'h0);
  endtask

  task automatic t_txw();
    @(negedge clk); idle(); ev_txw = 1; step();
    chk("R9 tx byte sets bit2", src_q, 4'h4);
    clear_all();
  endtask

  task automatic t_collide();
    @(negedge clk); idle(); ev_err = 1; step();
    @(negedge clk); idle(); ev_err = 1; wr_pend = 1; wr_data = 4'h2; step();
    chk("R10 event wins pend", src_q, 4'h2);
    @(negedge clk); idle(); ev_rx = 1; wr_src = 1; wr_data = 4'h3; step();
    chk("R10 event wins src", src_q, 4'h1);
    clear_all();
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); fifo_en = 0; tx_trig = 0; tx_count = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_events();
    t_pend_clear();
    t_src_clear();
    t_mask();
    t_trigger();
    t_fifo_off();
    t_txw();
    t_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule